// File: doc/BRIEF.md
# Paged flash ROM bank mapper

This block places a 128kB flash ROM into two memory regions of an 8-bit computer: a 16kB home ROM window at the bottom of the home bank, and the full 64kB expansion bank. It holds a write-only page register at I/O address 0xD0 and drives the three upper flash address lines and the flash chip enable, which is active low. In the home window the page register normally picks one of eight 16kB pages. Two of its bits can hand a flash address line over to a live signal instead. One is a compatibility bit captured from writes to port 0x7FFD. The other is the CPU opcode-fetch strobe, so that opcode fetches and data reads of the same address can return different pages.

In the expansion bank the upper page line is forced high and the two lower lines follow the CPU address, so flash pages 4 to 7 form one contiguous 64kB region. An external SRAM mapper can take priority over the flash there through an inhibit input. After reset the home window shows page 0 and the ROM stays enabled until software first writes the page register, whatever enable bit it then writes.

Top module: `flash_page_mapper`

## Requirements
- R1: After reset, with neither register written, the home window presents page 0: flash address lines {A16,A15,A14} = 3'b000.
- R2: A write to I/O port 0xD0 (low address byte 0xD0, /IORQ low, /WR low, /M1 high) loads the page register. With register bits 5 and 6 clear, bits 0, 1 and 2 appear on flash A14, A15 and A16 during home-window accesses from the next cycle on.
- R3: Once the page register has been written, home-window accesses enable the flash only if register bit 7 was written as 1. With bit 7 written as 0 the chip enable stays high in the home window.
- R4: From reset until the first write to port 0xD0, home-window accesses with /MREQ low enable the flash regardless of any other input.
- R5: When register bit 5 is 1, flash A14 in the home window equals bit 4 of the last write to port 0x7FFD (full 16-bit address match; cleared by reset) and register bit 0 has no effect.
- R6: When register bit 6 is 1, flash A15 in the home window equals the /M1 input (0 during an opcode fetch, 1 otherwise) and register bit 1 has no effect. Writing 0xC1 gives page 1 on opcode fetches and page 3 on data reads. Writing 0xA6 or 0xA7 gives page 6 or 7 as picked by the 0x7FFD bit.
- R7: In the expansion bank (bank select input = 1) flash A16 is 1 and A15/A14 equal CPU A15/A14, independent of the page register.
- R8: In the expansion bank the chip enable is asserted when /MREQ is low and the SRAM inhibit is low. A high SRAM inhibit keeps it deasserted. The inhibit has no effect on the home bank.
- R9: The chip enable is deasserted whenever /MREQ is high, and for home-bank accesses outside the lowest 16kB.
- R10: I/O writes whose low byte is not 0xD0, or that occur with /M1 low, leave the page register unchanged. Writes to any 16-bit address other than 0x7FFD leave the compatibility bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock on which port writes are captured |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (write data) |
| iorq_ni | input | 1 | I/O request, active low |
| wr_ni | input | 1 | Write strobe, active low |
| mreq_ni | input | 1 | Memory request, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| bank_exp_i | input | 1 | Bank select: 0 home bank, 1 expansion bank |
| sram_claim_i | input | 1 | SRAM mapper owns this expansion access; inhibits flash |
| rom_addr_o | output | 3 | Flash address lines {A16,A15,A14} |
| rom_ce_no | output | 1 | Flash chip enable, active low |

## Verification
Flash address lines and the chip enable are combinational in the bus inputs and the stored state, so they are due in the same cycle as a bus stimulus. Port writes take effect at the next rising edge. The bench drives every input on the falling edge and compares the outputs a short delay later against a model that still holds the pre-edge state. It then advances that model on the rising edge for any write the cycle carried. A write therefore shows in the check of the following cycle and never in the one that issued it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Stored mapper state: page-register fields plus reset tracking
    typedef struct packed {
        logic [2:0] sel;       // page select, bits 2..0 of the page register
        logic       a14_live;  // A14 follows the compatibility bit
        logic       a15_live;  // A15 follows the opcode-fetch strobe
        logic       rom_en;    // home-window enable bit
        logic       forced;    // ROM forced on until first page write
        logic       compat;    // captured compatibility bit
    } map_state_t;

    localparam map_state_t MAP_RESET = '{
        sel:      3'b000,
        a14_live: 1'b0,
        a15_live: 1'b0,
        rom_en:   1'b0,
        forced:   1'b1,
        compat:   1'b0
    };

endpackage

// File: rtl/fpm_port_decode.sv
module fpm_port_decode #(
    parameter int          ADDR_W      = 16,
    parameter logic [7:0]  PAGE_PORT   = 8'hD0,
    parameter logic [15:0] COMPAT_PORT = 16'h7FFD,
    parameter bit          COMPAT_FULL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              iorq_ni,
    input  logic              wr_ni,
    input  logic              m1_ni,
    output logic              ld_page_o,
    output logic              ld_compat_o
);

    logic io_wr;
    logic compat_hit;

    // A genuine I/O write cycle, not an interrupt acknowledge
    assign io_wr = !iorq_ni && !wr_ni && m1_ni;

    assign ld_page_o = io_wr && (addr_i[7:0] == PAGE_PORT);

    generate
        if (COMPAT_FULL) begin : g_full
            assign compat_hit = (addr_i == COMPAT_PORT[ADDR_W-1:0]);
        end else begin : g_partial
            // Partial decode: A15 low and A1 low
            assign compat_hit = !addr_i[ADDR_W-1] && !addr_i[1];
        end
    endgenerate

    assign ld_compat_o = io_wr && compat_hit;

endmodule

// File: rtl/fpm_page_regs.sv
module fpm_page_regs
    import fpm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BITS  = 3,
    parameter int LIVE14_BIT = 5,
    parameter int LIVE15_BIT = 6,
    parameter int EN_BIT     = 7,
    parameter int COMPAT_BIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ld_page_i,
    input  logic              ld_compat_i,
    output map_state_t        state_o
);

    map_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ld_page_i) begin
            state_d.sel      = data_i[PAGE_BITS-1:0];
            state_d.a14_live = data_i[LIVE14_BIT];
            state_d.a15_live = data_i[LIVE15_BIT];
            state_d.rom_en   = data_i[EN_BIT];
            state_d.forced   = 1'b0;
        end
        if (ld_compat_i) begin
            state_d.compat = data_i[COMPAT_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MAP_RESET;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

    // R2
    page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_page_i |=> (state_q.sel == $past(data_i[PAGE_BITS-1:0])));

    // R4
    force_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(state_q.forced) |-> $past(ld_page_i));

    // R10
    compat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_compat_i |=> $stable(state_q.compat));

endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux
    import fpm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 3,
    parameter int WIN_LSB   = 14
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 mreq_ni,
    input  logic                 m1_ni,
    input  logic                 bank_exp_i,
    input  logic                 sram_claim_i,
    input  map_state_t           state_i,
    output logic [PAGE_BITS-1:0] rom_addr_o,
    output logic                 rom_ce_no
);

    localparam int WIN_W = ADDR_W - WIN_LSB;

    logic [PAGE_BITS-1:0] home_line;
    logic [PAGE_BITS-1:0] exp_line;
    logic                 in_home_win;
    logic                 home_sel;
    logic                 exp_sel;

    generate
        for (genvar i = 0; i < PAGE_BITS; i++) begin : g_line
            if (i == 0) begin : g_a14
                assign home_line[i] = state_i.a14_live ? state_i.compat : state_i.sel[i];
            end else if (i == 1) begin : g_a15
                assign home_line[i] = state_i.a15_live ? m1_ni : state_i.sel[i];
            end else begin : g_upper
                assign home_line[i] = state_i.sel[i];
            end

            if (i < WIN_W) begin : g_cpu
                assign exp_line[i] = addr_i[WIN_LSB+i];
            end else begin : g_tie
                assign exp_line[i] = 1'b1;
            end
        end
    endgenerate

    assign in_home_win = (addr_i[ADDR_W-1:WIN_LSB] == '0);
    assign home_sel    = !bank_exp_i && in_home_win && (state_i.forced || state_i.rom_en);
    assign exp_sel     = bank_exp_i && !sram_claim_i;

    assign rom_addr_o = bank_exp_i ? exp_line : home_line;
    assign rom_ce_no  = !(!mreq_ni && (home_sel || exp_sel));

endmodule

// File: rtl/flash_page_mapper.sv
module flash_page_mapper
    import fpm_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          PAGE_BITS   = 3,
    parameter int          WIN_LSB     = 14,
    parameter logic [7:0]  PAGE_PORT   = 8'hD0,
    parameter logic [15:0] COMPAT_PORT = 16'h7FFD
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic                 iorq_ni,
    input  logic                 wr_ni,
    input  logic                 mreq_ni,
    input  logic                 m1_ni,
    input  logic                 bank_exp_i,
    input  logic                 sram_claim_i,
    output logic [PAGE_BITS-1:0] rom_addr_o,
    output logic                 rom_ce_no
);

    logic       ld_page;
    logic       ld_compat;
    map_state_t state;
    logic       unused_data3;

    assign unused_data3 = data_i[3];

    fpm_port_decode #(
        .ADDR_W      (ADDR_W),
        .PAGE_PORT   (PAGE_PORT),
        .COMPAT_PORT (COMPAT_PORT),
        .COMPAT_FULL (1'b1)
    ) u_decode (
        .addr_i      (addr_i),
        .iorq_ni     (iorq_ni),
        .wr_ni       (wr_ni),
        .m1_ni       (m1_ni),
        .ld_page_o   (ld_page),
        .ld_compat_o (ld_compat)
    );

    fpm_page_regs #(
        .DATA_W    (DATA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .data_i      (data_i),
        .ld_page_i   (ld_page),
        .ld_compat_i (ld_compat),
        .state_o     (state)
    );

    fpm_addr_mux #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .WIN_LSB   (WIN_LSB)
    ) u_mux (
        .addr_i       (addr_i),
        .mreq_ni      (mreq_ni),
        .m1_ni        (m1_ni),
        .bank_exp_i   (bank_exp_i),
        .sram_claim_i (sram_claim_i),
        .state_i      (state),
        .rom_addr_o   (rom_addr_o),
        .rom_ce_no    (rom_ce_no)
    );

    // R7
    exp_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_exp_i |-> (rom_addr_o == {1'b1, addr_i[ADDR_W-1:WIN_LSB]}));

    // R8
    sram_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bank_exp_i && sram_claim_i) |-> rom_ce_no);

    // R9
    mreq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mreq_ni |-> rom_ce_no);

    // R9
    home_outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bank_exp_i && (addr_i[ADDR_W-1:WIN_LSB] != '0)) |-> rom_ce_no);

endmodule

// File: tb/flash_page_mapper_bench.sv
module flash_page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        iorq_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, m1_n = 1'b1;
    logic        bank = 1'b0, claim = 1'b0;
    logic [2:0]  rom_addr;
    logic        rom_ce_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    logic [7:0] m_page   = 8'h00;
    logic       m_forced = 1'b1;
    logic       m_compat = 1'b0;

    always #2 clk = ~clk;

    flash_page_mapper u_flash_page_mapper (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
        .iorq_ni(iorq_n), .wr_ni(wr_n), .mreq_ni(mreq_n), .m1_ni(m1_n),
        .bank_exp_i(bank), .sram_claim_i(claim),
        .rom_addr_o(rom_addr), .rom_ce_no(rom_ce_n)
    );

    function automatic logic [2:0] exp_lines();
        if (bank) return {1'b1, addr[15:14]};
        return {m_page[2], m_page[6] ? m1_n : m_page[1], m_page[5] ? m_compat : m_page[0]};
    endfunction

    function automatic logic exp_ce_n();
        logic hit;
        hit = bank ? !claim : (addr[15:14] == 2'b00 && (m_forced || m_page[7]));
        return !(!mreq_n && hit);
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on falling edge, check, then advance the model at the rising edge
    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic io, input logic w,
                       input logic mq, input logic m1, input logic b, input logic c,
                       input string tag_a, input string tag_c);
        @(negedge clk);
        addr = a; data = d; iorq_n = io; wr_n = w; mreq_n = mq; m1_n = m1; bank = b; claim = c;
        #1;
        check(tag_a, {1'b0, rom_addr}, {1'b0, exp_lines()});
        check(tag_c, {3'b0, rom_ce_n}, {3'b0, exp_ce_n()});
        @(posedge clk);
        if (!io && !w && m1 && a[7:0] == 8'hD0) begin
            m_page = d; m_forced = 1'b0;
        end
        if (!io && !w && m1 && a == 16'h7FFD) m_compat = d[4];
    endtask

    task automatic iowr(input logic [15:0] a, input logic [7:0] d);
        cyc(a, d, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10", "R9");
    endtask

    task automatic rd(input logic [15:0] a, input logic m1, input logic b, input logic c,
                      input string ta, input string tc);
        cyc(a, 8'h00, 1'b1, 1'b1, 1'b0, m1, b, c, ta, tc);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R4: reset state, forced enable
        rd(16'h0123, 1'b1, 1'b0, 1'b0, "R1", "R4");
        rd(16'h3FFF, 1'b0, 1'b0, 1'b1, "R1", "R4");
        // R10: wrong port, interrupt-ack cycle, near-miss compat port
        iowr(16'h00D1, 8'h05);
        cyc(16'h00D0, 8'h06, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10", "R10");
        iowr(16'h7FFE, 8'h10);
        rd(16'h0000, 1'b1, 1'b0, 1'b0, "R10", "R4");
        // R2: plain page select
        iowr(16'h12D0, 8'h85);
        rd(16'h1000, 1'b1, 1'b0, 1'b0, "R2", "R3");
        rd(16'h1000, 1'b0, 1'b0, 1'b0, "R2", "R3");
        // R3: enable bit cleared after first write
        iowr(16'h00D0, 8'h02);
        rd(16'h2000, 1'b1, 1'b0, 1'b0, "R2", "R3");
        // R6: opcode-fetch page split
        iowr(16'h00D0, 8'hC1);
        rd(16'h3D00, 1'b0, 1'b0, 1'b0, "R6", "R3");
        rd(16'h3D00, 1'b1, 1'b0, 1'b0, "R6", "R3");
        // R5: compat bit drives A14
        iowr(16'h00D0, 8'hA6);
        rd(16'h0100, 1'b1, 1'b0, 1'b0, "R5", "R3");
        iowr(16'h7FFD, 8'h10);
        rd(16'h0100, 1'b1, 1'b0, 1'b0, "R5", "R3");
        iowr(16'h00D0, 8'hA7);
        iowr(16'h7FFD, 8'h00);
        rd(16'h0100, 1'b1, 1'b0, 1'b0, "R5", "R3");
        // R7 / R8 / R9: expansion bank and idle bus
        rd(16'hC000, 1'b1, 1'b1, 1'b0, "R7", "R8");
        rd(16'h4000, 1'b0, 1'b1, 1'b1, "R7", "R8");
        rd(16'h8000, 1'b1, 1'b0, 1'b0, "R1", "R9");
        cyc(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2", "R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          kind;
            kind = $urandom_range(0, 9);
            a = 16'($urandom);
            d = 8'($urandom);
            if (kind == 0) a[7:0] = 8'hD0;
            if (kind == 1) a = 16'h7FFD;
            if (kind < 3) begin
                cyc(a, d, 1'b0, 1'b0, 1'b1, 1'($urandom_range(0, 3) != 0), 1'b0, 1'b0, "R10", "R9");
            end else begin
                logic b;
                b = 1'($urandom);
                if (!b && kind < 7) a[15:14] = 2'b00;
                cyc(a, d, 1'b1, 1'b1, 1'($urandom_range(0, 4) == 0), 1'($urandom),
                    b, 1'($urandom), b ? "R7" : "R6", b ? "R8" : "R3");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule